// File: doc/BRIEF.md
# Write-Through Streaming Data Cache

This block is a small set-associative data cache that sits between one processor load/store port and a downstream memory port. Loads that miss fetch a whole line from below and wait for it. Stores are always forwarded downstream; a store that hits also patches the bytes it writes in the cached line, and a store that misses leaves the cache untouched. This keeps one-shot output streams from pushing useful lines out.

A third request kind, the stream prefetch, pulls a line into this cache without stalling the processor. Its downstream read carries a flag that tells the next level not to keep its own copy, so read streams pass around the next level's storage. Several fills may be outstanding at once. Responses come back in request order, and any access that meets a line whose fill is still in flight waits for it.

Top module: `wt_nwa_dcache`

## Requirements
- R1: After reset every line is invalid, `rsp_valid` and `mem_req_valid` are low while no request is presented, and the first load of any address misses.
- R2: A load miss raises one downstream read (`mem_req_write`=0, `mem_req_nokeep`=0) whose address is the load address with its low log2(LINE_BYTES) bits cleared. The load is not accepted until the fill has returned.
- R3: A load that hits is accepted without a downstream request, and `rsp_valid` rises in the cycle after acceptance with the addressed 32-bit word of the line.
- R4: Every store, hit or miss, is forwarded downstream with `mem_req_write`=1 and the store's address, data and byte enables. It is accepted only in a cycle where `mem_req_ready` is high.
- R5: A store that misses allocates nothing: a later load of that address still misses.
- R6: A store that hits updates exactly the bytes whose `req_be` bit is set (bit b covers data bits 8b+7..8b), and a later load returns the merged word.
- R7: A prefetch that misses raises a line-aligned read with `mem_req_nokeep`=1 and is accepted without waiting for the fill. After the fill the line hits.
- R8: A prefetch that hits or meets an in-flight fill of its line raises no downstream request.
- R9: At most MAX_OUT (default 8) fills are in flight. A miss that finds that many waiting is held, with no request, until a response arrives.
- R10: A load to a line whose fill is still in flight is held, raises no second read, and completes once that fill arrives.
- R11: Within a set the victim is the lowest-numbered way that is neither valid nor being filled. When there is none, a three-bit tree pseudo-LRU chooses, updated on every hit and every allocation.
- R12: Each `mem_rsp_valid` pulse delivers the line of the oldest fill still in flight, and that line is written to the way that was reserved for it.
- R13: `req_op` encodes 0 = load, 1 = store, 2 = prefetch; 3 behaves as a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 prefetch |
| req_addr | input | ADDR_W | Byte address (word aligned) |
| req_wdata | input | WORD_W | Store data |
| req_be | input | WORD_BYTES | Store byte enables |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | WORD_W | Load data |
| mem_req_valid | output | 1 | Downstream request present |
| mem_req_ready | input | 1 | Downstream request taken |
| mem_req_write | output | 1 | 1 write-through store, 0 line read |
| mem_req_nokeep | output | 1 | Next level must not retain the line |
| mem_req_addr | output | ADDR_W | Downstream address |
| mem_req_wdata | output | WORD_W | Store data forwarded |
| mem_req_be | output | WORD_BYTES | Store byte enables forwarded, zero on reads |
| mem_rsp_valid | input | 1 | Fill line returned, in request order |
| mem_rsp_line | input | LINE_BYTES*8 | Fill data, word i at bits 32i+31..32i |

## Verification
Loads go to cold lines, to filled lines and to lines still in flight. This tells a true miss from a hit and from a wait on a pending fill; a duplicate read shows up in the request count. Stores are sent to a resident line with partial byte enables and to an absent line, which separates a byte merge from a write-through with no allocation. A burst of prefetches fills the in-flight limit, so the held ninth miss and the order in which responses land can be seen. A set is then filled, one way is touched and a new line is forced in, and the line that is evicted shows which replacement order was taken.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_PREF  = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;
endpackage

// File: rtl/wt_plru4.sv
module wt_plru4 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       touch_en,
  input  logic [1:0] touch_way,
  output logic [1:0] victim
);
  // tree[0]: victim in upper pair; tree[1]: way1 within lower; tree[2]: way3 within upper
  logic [2:0] tree_q, tree_d;

  always_comb begin
    tree_d = tree_q;
    if (touch_en) begin
      tree_d[0] = ~touch_way[1];
      if (!touch_way[1]) tree_d[1] = ~touch_way[0];
      else               tree_d[2] = ~touch_way[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tree_q <= 3'b000;
    else if (touch_en) tree_q <= tree_d;
  end

  assign victim = tree_q[0] ? {1'b1, tree_q[2]} : {1'b0, tree_q[1]};

  // the way just touched is never the next victim
  p_touch_not_victim_r11: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> victim != $past(touch_way));
endmodule

// File: rtl/wt_fill_fifo.sv
module wt_fill_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q, wr_d, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = push ? ((wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1) : wr_q;
    rd_d  = pop  ? ((rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1) : rd_q;
    cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (push || pop) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= push_data;
  end

  assign head  = mem_q[rd_q];
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/wt_nwa_dcache.sv
module wt_nwa_dcache
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int LINE_BYTES = 128,
  parameter int SETS       = 4,
  parameter int MAX_OUT    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [1:0]                req_op,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [WORD_BYTES*8-1:0]   req_wdata,
  input  logic [WORD_BYTES-1:0]     req_be,
  output logic                      rsp_valid,
  output logic [WORD_BYTES*8-1:0]   rsp_rdata,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic                      mem_req_write,
  output logic                      mem_req_nokeep,
  output logic [ADDR_W-1:0]         mem_req_addr,
  output logic [WORD_BYTES*8-1:0]   mem_req_wdata,
  output logic [WORD_BYTES-1:0]     mem_req_be,
  input  logic                      mem_rsp_valid,
  input  logic [LINE_BYTES*8-1:0]   mem_rsp_line
);
  localparam int WAYS   = 4;  // fixed by the three-bit replacement tree
  localparam int WAY_W  = 2;
  localparam int WORD_W = WORD_BYTES * 8;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WB_W   = $clog2(WORD_BYTES);
  localparam int WSEL_W = OFF_W - WB_W;
  localparam int QW     = IDX_W + WAY_W;

  logic [LINE_W-1:0] data_q [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [WAYS-1:0]   val_q  [SETS];
  logic [WAYS-1:0]   pend_q [SETS];

  op_e               op;
  logic [IDX_W-1:0]  set_i;
  logic [TAG_W-1:0]  tag_i;
  logic [WSEL_W-1:0] wsel;
  logic              hit_v, hit_p, free_f, alloc_ok, accept, fill_go;
  logic [WAY_W-1:0]  hit_way, free_way, vic_way;
  logic [WAY_W-1:0]  plru_vic [SETS];
  logic [QW-1:0]     q_head;
  logic              q_full, q_empty;
  logic [IDX_W-1:0]  f_set;
  logic [WAY_W-1:0]  f_way;

  assign op    = op_e'(req_op);
  assign set_i = req_addr[OFF_W +: IDX_W];
  assign tag_i = req_addr[ADDR_W-1 -: TAG_W];
  assign wsel  = req_addr[WB_W +: WSEL_W];

  // lookup and victim choice
  always_comb begin
    hit_v = 1'b0; hit_p = 1'b0; hit_way = '0;
    free_f = 1'b0; free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (tag_q[set_i][w] == tag_i && (val_q[set_i][w] || pend_q[set_i][w])) begin
        hit_way = WAY_W'(w);
        hit_v   = val_q[set_i][w];
        hit_p   = pend_q[set_i][w];
      end
      if (!val_q[set_i][w] && !pend_q[set_i][w]) begin
        free_f   = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    vic_way  = free_f ? free_way : plru_vic[set_i];
    alloc_ok = !q_full && !pend_q[set_i][vic_way];
  end

  // request control
  always_comb begin
    mem_req_write  = 1'b0;
    mem_req_nokeep = 1'b0;
    mem_req_valid  = 1'b0;
    req_ready      = 1'b0;
    unique case (op)
      OP_STORE: begin
        mem_req_write = 1'b1;
        mem_req_valid = req_valid && !hit_p;
        req_ready     = req_valid && !hit_p && mem_req_ready;
      end
      OP_PREF: begin
        mem_req_nokeep = 1'b1;
        mem_req_valid  = req_valid && !hit_v && !hit_p && alloc_ok;
        req_ready      = req_valid && (hit_v || hit_p || (alloc_ok && mem_req_ready));
      end
      default: begin
        mem_req_valid = req_valid && !hit_v && !hit_p && alloc_ok;
        req_ready     = req_valid && hit_v;
      end
    endcase
  end

  assign accept        = req_valid && req_ready;
  assign fill_go       = mem_req_valid && mem_req_ready && !mem_req_write;
  assign mem_req_addr  = mem_req_write ? req_addr : {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_req_wdata = req_wdata;
  assign mem_req_be    = mem_req_write ? req_be : '0;

  // replacement state, one tree per set
  for (genvar s = 0; s < SETS; s++) begin : g_plru
    wt_plru4 u_plru (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch_en  ((set_i == IDX_W'(s)) && ((accept && hit_v) || fill_go)),
      .touch_way (fill_go ? vic_way : hit_way),
      .victim    (plru_vic[s])
    );
  end

  wt_fill_fifo #(.DEPTH(MAX_OUT), .W(QW)) u_fillq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (fill_go),
    .push_data ({set_i, vic_way}),
    .pop       (mem_rsp_valid),
    .head      (q_head),
    .full      (q_full),
    .empty     (q_empty)
  );
  assign {f_set, f_way} = q_head;

  // line state: reservation at issue, completion at response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        val_q[s]  <= '0;
        pend_q[s] <= '0;
      end
    end else begin
      if (fill_go) begin
        val_q[set_i][vic_way]  <= 1'b0;
        pend_q[set_i][vic_way] <= 1'b1;
      end
      if (mem_rsp_valid) begin
        val_q[f_set][f_way]  <= 1'b1;
        pend_q[f_set][f_way] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) tag_q[set_i][vic_way] <= tag_i;
    if (mem_rsp_valid) data_q[f_set][f_way] <= mem_rsp_line;
    if (accept && op == OP_STORE && hit_v) begin
      for (int b = 0; b < WORD_BYTES; b++) begin
        if (req_be[b]) data_q[set_i][hit_way][(int'(wsel) * WORD_BYTES + b) * 8 +: 8] <= req_wdata[b*8 +: 8];
      end
    end
  end

  // load response
  logic load_acc;
  assign load_acc = accept && op != OP_STORE && op != OP_PREF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= load_acc;
  end

  always_ff @(posedge clk) begin
    if (load_acc) rsp_rdata <= data_q[set_i][hit_way][int'(wsel) * WORD_W +: WORD_W];
  end

  p_store_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == 2'd1) |-> (mem_req_valid && mem_req_ready && mem_req_write && mem_req_addr == req_addr));
  p_load_rsp_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_op == 2'd0 || req_op == 2'd3)) |=> rsp_valid);
  p_read_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write) |-> (mem_req_addr[OFF_W-1:0] == '0));
  p_nokeep_pref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_nokeep) |-> (!mem_req_write && req_op == 2'd2));
  p_rsp_only_inflight_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !q_empty);
endmodule

// File: tb/wt_nwa_dcache_tb.sv
module wt_nwa_dcache_tb;
  logic         clk, rst_n;
  logic         req_valid, req_ready;
  logic [1:0]   req_op;
  logic [31:0]  req_addr, req_wdata;
  logic [3:0]   req_be;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         mem_req_valid, mem_req_ready, mem_req_write, mem_req_nokeep;
  logic [31:0]  mem_req_addr, mem_req_wdata;
  logic [3:0]   mem_req_be;
  logic         mem_rsp_valid;
  logic [1023:0] mem_rsp_line;

  int checks = 0, errors = 0;
  int acc_cnt = 0, rd_cnt = 0, wr_cnt = 0, rd_head = 0, rd_tail = 0;
  logic [31:0] rd_q [16];
  logic        last_nokeep;
  logic [31:0] last_rd_addr, last_wr_addr, last_wr_data;
  logic [3:0]  last_wr_be;
  bit          done = 0;

  wt_nwa_dcache u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_nokeep(mem_req_nokeep),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // handshake monitor (reads values settled before the edge)
  always @(posedge clk) begin
    if (rst_n) begin
      if (req_valid && req_ready) acc_cnt++;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          wr_cnt++;
          last_wr_addr = mem_req_addr;
          last_wr_data = mem_req_wdata;
          last_wr_be   = mem_req_be;
        end else begin
          rd_q[rd_tail % 16] = mem_req_addr;
          rd_tail++;
          rd_cnt++;
          last_rd_addr = mem_req_addr;
          last_nokeep  = mem_req_nokeep;
        end
      end
    end
  end

  function automatic logic [31:0] wv(input logic [31:0] a);
    return (a * 32'h0001_0003) ^ 32'h5A5A_5A5A;
  endfunction

  function automatic logic [1023:0] mkline(input logic [31:0] la);
    logic [1023:0] l;
    for (int i = 0; i < 32; i++) l[i*32 +: 32] = wv(la + 32'(i * 4));
    return l;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // present one request at a negedge; optionally answer fills in order
  task automatic core_op(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] wd,
                         input logic [3:0] be, input int maxwait, input bit auto_f,
                         output bit acc, output bit rv, output logic [31:0] data);
    int start = acc_cnt;
    acc = 0;
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd; req_be = be;
    for (int i = 0; i < maxwait; i++) begin
      if (auto_f && rd_tail != rd_head) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_line  = mkline(rd_q[rd_head % 16]);
        rd_head++;
      end else mem_rsp_valid = 1'b0;
      @(negedge clk);
      if (acc_cnt != start) begin acc = 1; break; end
    end
    mem_rsp_valid = 1'b0;
    req_valid = 1'b0;
    rv = rsp_valid;
    data = rsp_rdata;
  endtask

  task automatic drain();
    while (rd_tail != rd_head) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_line  = mkline(rd_q[rd_head % 16]);
      rd_head++;
      @(negedge clk);
    end
    mem_rsp_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid idle", 32'(rsp_valid), 0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid idle", 32'(mem_req_valid), 0);
  endtask

  task automatic t_load_miss_hit();
    bit a, rv; logic [31:0] d; int r0 = rd_cnt;
    core_op(2'd0, 32'h1000, 0, 0, 4, 0, a, rv, d);
    chk(!a, "R2 load miss held", 32'(a), 0);
    chk(rd_cnt == r0 + 1, "R10 single read while held", 32'(rd_cnt - r0), 1);
    chk(last_rd_addr == 32'h1000 && !last_nokeep, "R1 R2 first load reads line", last_rd_addr, 32'h1000);
    core_op(2'd0, 32'h1000, 0, 0, 10, 1, a, rv, d);
    chk(a && rv && d == wv(32'h1000), "R2 load data after fill", d, wv(32'h1000));
    r0 = rd_cnt;
    core_op(2'd3, 32'h1004, 0, 0, 3, 0, a, rv, d);
    chk(a && rv && d == wv(32'h1004), "R3 R13 hit word", d, wv(32'h1004));
    chk(rd_cnt == r0, "R3 hit no read", 32'(rd_cnt - r0), 0);
  endtask

  task automatic t_stores();
    bit a, rv; logic [31:0] d; int w0 = wr_cnt; int r0;
    mem_req_ready = 1'b0;
    core_op(2'd1, 32'h1008, 32'hDEAD_BEEF, 4'b0011, 3, 0, a, rv, d);
    chk(!a && wr_cnt == w0, "R4 store waits for ready", 32'(a), 0);
    mem_req_ready = 1'b1;
    core_op(2'd1, 32'h1008, 32'hDEAD_BEEF, 4'b0011, 3, 0, a, rv, d);
    chk(a && wr_cnt == w0 + 1 && last_wr_addr == 32'h1008, "R4 hit store forwarded", last_wr_addr, 32'h1008);
    chk(last_wr_data == 32'hDEAD_BEEF && last_wr_be == 4'b0011, "R4 store data/be", last_wr_data, 32'hDEAD_BEEF);
    core_op(2'd0, 32'h1008, 0, 0, 3, 0, a, rv, d);
    chk(a && d == {wv(32'h1008)[31:16], 16'hBEEF}, "R6 byte merge", d, {wv(32'h1008)[31:16], 16'hBEEF});
    core_op(2'd1, 32'h2000, 32'h1234_5678, 4'b1111, 3, 0, a, rv, d);
    chk(a && wr_cnt == w0 + 2 && last_wr_addr == 32'h2000, "R4 miss store forwarded", last_wr_addr, 32'h2000);
    r0 = rd_cnt;
    core_op(2'd0, 32'h2000, 0, 0, 10, 1, a, rv, d);
    chk(rd_cnt == r0 + 1, "R5 store miss no allocate", 32'(rd_cnt - r0), 1);
    chk(a && d == wv(32'h2000), "R5 fresh fill data", d, wv(32'h2000));
  endtask

  task automatic t_prefetch();
    bit a, rv; logic [31:0] d; int r0 = rd_cnt;
    core_op(2'd2, 32'h3100, 0, 0, 3, 0, a, rv, d);
    chk(a && !rv, "R7 prefetch accepted before fill", 32'(a), 1);
    chk(rd_cnt == r0 + 1 && last_nokeep && last_rd_addr == 32'h3100, "R7 no-keep read", last_rd_addr, 32'h3100);
    core_op(2'd2, 32'h3100, 0, 0, 3, 0, a, rv, d);
    chk(a && rd_cnt == r0 + 1, "R8 prefetch of in-flight line", 32'(rd_cnt - r0), 1);
    drain();
    core_op(2'd0, 32'h3104, 0, 0, 3, 0, a, rv, d);
    chk(a && rd_cnt == r0 + 1 && d == wv(32'h3104), "R7 prefetched line hits", d, wv(32'h3104));
    core_op(2'd2, 32'h3100, 0, 0, 3, 0, a, rv, d);
    chk(a && rd_cnt == r0 + 1, "R8 prefetch hit no read", 32'(rd_cnt - r0), 1);
  endtask

  task automatic t_outstanding();
    bit a, rv; logic [31:0] d; int r0 = rd_cnt;
    logic [31:0] pa [8] = '{32'h4180, 32'h4380, 32'h4580, 32'h4780,
                            32'h3300, 32'h3500, 32'h3700, 32'h5000};
    for (int i = 0; i < 8; i++) core_op(2'd2, pa[i], 0, 0, 3, 0, a, rv, d);
    chk(rd_cnt == r0 + 8, "R9 eight fills in flight", 32'(rd_cnt - r0), 8);
    core_op(2'd2, 32'h5200, 0, 0, 4, 0, a, rv, d);
    chk(!a && rd_cnt == r0 + 8, "R9 ninth miss held", 32'(rd_cnt - r0), 8);
    core_op(2'd0, 32'h4384, 0, 0, 4, 0, a, rv, d);
    chk(!a && rd_cnt == r0 + 8, "R10 load on pending line held", 32'(a), 0);
    core_op(2'd0, 32'h4384, 0, 0, 10, 1, a, rv, d);
    chk(a && d == wv(32'h4384), "R12 R10 in-order fill data", d, wv(32'h4384));
    drain();
    core_op(2'd2, 32'h5200, 0, 0, 3, 0, a, rv, d);
    chk(a && rd_cnt == r0 + 9 && last_nokeep, "R9 miss issued after drain", 32'(rd_cnt - r0), 9);
    drain();
    core_op(2'd0, 32'h3708, 0, 0, 3, 0, a, rv, d);
    chk(a && d == wv(32'h3708), "R12 later fill placed", d, wv(32'h3708));
  endtask

  task automatic t_replace();
    bit a, rv; logic [31:0] d; int r0;
    logic [31:0] la [4] = '{32'h10080, 32'h10280, 32'h10480, 32'h10680};
    for (int i = 0; i < 4; i++) core_op(2'd0, la[i], 0, 0, 10, 1, a, rv, d);
    core_op(2'd0, la[0], 0, 0, 3, 0, a, rv, d);
    core_op(2'd0, 32'h10880, 0, 0, 10, 1, a, rv, d);
    r0 = rd_cnt;
    core_op(2'd0, la[3], 0, 0, 3, 0, a, rv, d);
    core_op(2'd0, la[1], 0, 0, 3, 0, a, rv, d);
    core_op(2'd0, la[0], 0, 0, 3, 0, a, rv, d);
    chk(a && rd_cnt == r0 && d == wv(la[0]), "R11 survivors still hit", 32'(rd_cnt - r0), 0);
    core_op(2'd0, la[2], 0, 0, 3, 0, a, rv, d);
    chk(!a && rd_cnt == r0 + 1, "R11 pseudo-LRU evicted way 2", 32'(rd_cnt - r0), 1);
    drain();
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_addr = '0; req_wdata = '0;
    req_be = '0; mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_line = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_miss_hit();
    t_stores();
    t_prefetch();
    t_outstanding();
    t_replace();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule